// File: doc/BRIEF.md
# Serial Byte Transmitter with Ready/Valid Input

This block turns bytes from on-chip logic into an asynchronous serial bit stream on a single output line. A producer offers a byte on `in_data` with `in_valid` raised. The block takes it on a cycle where its `in_ready` is also high. It then sends a low start bit, the data bits least significant first, and a high stop bit. Each bit is held for a fixed number of system clock cycles, equal to the clock frequency divided by the baud rate.

Control is a four-state machine. `TX_IDLE` drives the line high and raises ready. The transition *accept* (valid and ready both high) loads the framed byte and moves to `TX_START`. The transition *start_done* (end of a bit period) enters `TX_DATA`. `TX_DATA` repeats its own *data_next* transition once per bit period, and *data_done* on the last data bit enters `TX_STOP`. The transition *stop_done* returns to `TX_IDLE`. A producer that keeps `in_valid` high gets its next byte taken in the first idle cycle. That frame then starts one clock later, so consecutive frames follow with no gap beyond that single cycle.

Top module: `serial_tx_rv`

## Requirements
- R1: Whenever `in_ready` is high, `tx_line` is high (idle level), including throughout long idle stretches with `in_valid` low.
- R2: A synchronous active-high `rst` forces `tx_line` high and `in_ready` high at the next clock edge, even in the middle of a frame, and leaves no remnant of the aborted frame afterwards.
- R3: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the next cycle until the frame ends.
- R4: The start bit (`tx_line` low) begins in the cycle right after acceptance and lasts exactly CLK_HZ/BAUD cycles.
- R5: A frame is 10 bit periods of exactly CLK_HZ/BAUD cycles each: bit period 0 is the low start bit, bit periods 1 to 8 carry data bits 0 to 7 (least significant bit first), and bit period 9 is the stop bit.
- R6: The stop bit drives `tx_line` high for a full bit period before `in_ready` rises again.
- R7: `in_ready` rises in the first cycle after the stop bit period. A byte already held valid is accepted in that cycle, so consecutive start bits are exactly 10*CLK_HZ/BAUD + 1 cycles apart.
- R8: While `in_ready` is low, `in_data` and `in_valid` have no effect: each frame carries exactly the byte present at its accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_BITS | Byte offered by the producer |
| in_valid | input | 1 | Producer has a byte on `in_data` |
| in_ready | output | 1 | Block can take a byte this cycle |
| tx_line | output | 1 | Serial output, high when idle |

## Verification
The bench sends alternating patterns (0x55, 0xAA), all-zero and all-one bytes, and single-bit bytes (0x01, 0x80) each in isolation. These separate a bit-order reversal, a stuck or shifted data bit, and an off-by-one in the start or stop bit length. Every frame is sampled cycle by cycle against the expected waveform, so the bit period length is checked as well as the bit values. A back-to-back run with `in_valid` held high measures the start-to-start spacing. Another run offers changing junk while a frame is in progress to show that only the byte at acceptance is sent. A reset in mid-frame checks that the line and handshake return to idle.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_e;

endpackage

// File: rtl/tx_baud_timer.sv
module tx_baud_timer #(
    parameter int CYCLES_PER_BIT = 1085
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(CYCLES_PER_BIT + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 shift,
    input  logic [DATA_BITS-1:0] data,
    output logic                 line
);
    localparam int W = DATA_BITS + 2;

    logic [W-1:0] frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '1;
        end else if (load) begin
            frame_q <= {1'b1, data, 1'b0};
        end else if (shift) begin
            frame_q <= {1'b1, frame_q[W-1:1]};
        end
    end

    assign line = frame_q[0];

endmodule

// File: rtl/tx_ctrl_fsm.sv
module tx_ctrl_fsm
    import serial_tx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic tick,
    output logic ready,
    output logic load,
    output logic shift,
    output logic run
);
    localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_BITS - 1);

    tx_state_e     state_q, state_d;
    logic [IW-1:0] bit_idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || state_q != TX_DATA) begin
            bit_idx_q <= '0;
        end else if (tick) begin
            bit_idx_q <= bit_idx_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (in_valid)                          state_d = TX_START;
            TX_START: if (tick)                              state_d = TX_DATA;
            TX_DATA:  if (tick && bit_idx_q == LAST_IDX)     state_d = TX_STOP;
            TX_STOP:  if (tick)                              state_d = TX_IDLE;
            default:                                         state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        ready = (state_q == TX_IDLE);
        load  = ready && in_valid;
        run   = !ready;
        shift = tick;
    end

endmodule

// File: rtl/serial_tx_rv.sv
module serial_tx_rv #(
    parameter int CLK_HZ    = 125_000_000,
    parameter int BAUD      = 115_200,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DATA_BITS-1:0] in_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    output logic                 tx_line
);
    localparam int CYCLES_PER_BIT = CLK_HZ / BAUD;

    logic load, shift, run, bit_tick;

    tx_ctrl_fsm #(.DATA_BITS(DATA_BITS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .tick     (bit_tick),
        .ready    (in_ready),
        .load     (load),
        .shift    (shift),
        .run      (run)
    );

    tx_baud_timer #(.CYCLES_PER_BIT(CYCLES_PER_BIT)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (bit_tick)
    );

    tx_frame_shifter #(.DATA_BITS(DATA_BITS)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .shift (shift),
        .data  (in_data),
        .line  (tx_line)
    );

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> tx_line);

    // R3
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R4
    start_low_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !tx_line);

    // R5
    line_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(tx_line)) |-> $past(bit_tick || load));

    // R6
    stop_before_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(in_ready)) |-> (tx_line && $past(tx_line)));

endmodule

// File: tb/serial_tx_rv_test.sv
module serial_tx_rv_test;
    localparam int CLK_HZ = 1_000_000;
    localparam int BAUD   = 125_000;
    localparam int D      = CLK_HZ / BAUD;
    localparam int FB     = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       tx_line;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit mon_en = 1'b0;
    logic [7:0] exp_q[$];
    int start_cyc[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    serial_tx_rv #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_BITS(8)) uut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .tx_line(tx_line)
    );

    task automatic check(input bit cond, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: offers a byte; with noise, junk is shown while not ready (R8).
    task automatic send(input logic [7:0] d, input bit noise);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = noise ? 8'($urandom) : d;
        while (!in_ready) begin
            @(negedge clk);
            if (noise && !in_ready) in_data = 8'($urandom);
        end
        in_data = d;
        exp_q.push_back(d);
        @(negedge clk);
        check(in_ready == 1'b0, "R3", "ready after accept", in_ready, 0);
        check(tx_line == 1'b0, "R4", "start bit first cycle", tx_line, 0);
        in_valid = 1'b0;
        if (noise) in_data = 8'($urandom);
    endtask

    task automatic drain();
        do @(negedge clk); while (!(in_ready && exp_q.size() == 0));
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compares every cycle of a frame with the expected waveform.
    initial begin : monitor
        logic [7:0] e;
        logic [7:0] got;
        logic [FB-1:0] bits;
        bit ok;
        bit rdy_ok;
        forever begin
            @(negedge clk);
            if (mon_en && tx_line === 1'b0) begin
                start_cyc.push_back(cyc);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "frame with no byte queued", 1, 0);
                    e = 8'h00;
                end else begin
                    e = exp_q.pop_front();
                end
                bits = {1'b1, e, 1'b0};
                ok = 1'b1;
                rdy_ok = 1'b1;
                got = 8'h00;
                for (int k = 0; k < FB * D; k++) begin
                    if (k > 0) @(negedge clk);
                    if (tx_line !== bits[k / D]) ok = 1'b0;
                    if (in_ready !== 1'b0) rdy_ok = 1'b0;
                    if ((k % D) == D / 2 && k / D >= 1 && k / D <= 8)
                        got[k / D - 1] = tx_line;
                end
                check(ok, "R5", "frame waveform (byte lsb first, bit length)", got, e);
                check(rdy_ok, "R3", "ready low during frame", 1, 0);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        bit idle_ok;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx_line == 1'b1, "R2", "line after reset", tx_line, 1);
        check(in_ready == 1'b1, "R2", "ready after reset", in_ready, 1);

        // R1: long idle with data wiggling and valid low
        idle_ok = 1'b1;
        for (int i = 0; i < 3 * D; i++) begin
            in_data = 8'($urandom);
            @(negedge clk);
            if (!(tx_line && in_ready)) idle_ok = 1'b0;
        end
        check(idle_ok, "R1", "idle line high and ready", {tx_line, in_ready}, 3);

        // R2: reset in mid-frame, monitor off
        send(8'h00, 1'b0);
        repeat (3 * D) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(tx_line == 1'b1, "R2", "line after mid-frame reset", tx_line, 1);
        check(in_ready == 1'b1, "R2", "ready after mid-frame reset", in_ready, 1);
        rst = 1'b0;
        exp_q.delete();
        idle_ok = 1'b1;
        for (int i = 0; i < 2 * FB * D; i++) begin
            @(negedge clk);
            if (!(tx_line && in_ready)) idle_ok = 1'b0;
        end
        check(idle_ok, "R2", "no remnant of aborted frame", {tx_line, in_ready}, 3);

        mon_en = 1'b1;

        // R4 R5 R6: isolated frames with distinguishing patterns
        send(8'h55, 1'b0); drain();
        send(8'hAA, 1'b0); drain();
        send(8'h00, 1'b0); drain();
        send(8'hFF, 1'b0); drain();
        send(8'h01, 1'b0); drain();
        send(8'h80, 1'b0); drain();

        // R7: back-to-back frames with valid held
        start_cyc.delete();
        send(8'h3C, 1'b0);
        send(8'hC3, 1'b0);
        send(8'h96, 1'b0);
        send(8'h69, 1'b0);
        drain();
        check(start_cyc.size() == 4, "R7", "back-to-back frame count", start_cyc.size(), 4);
        for (int i = 1; i < start_cyc.size(); i++)
            check(start_cyc[i] - start_cyc[i-1] == FB * D + 1, "R7",
                  "start-to-start spacing", start_cyc[i] - start_cyc[i-1], FB * D + 1);

        // R8: junk offered with valid high during a frame is ignored
        send(8'hA5, 1'b0);
        send(8'h5A, 1'b1);
        send(8'hE7, 1'b1);
        drain();
        for (int i = 0; i < 4; i++) begin
            logic [7:0] r = 8'($urandom);
            send(r, 1'b1);
        end
        drain();

        check(exp_q.size() == 0, "R8", "every accepted byte framed once", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule